// File: doc/BRIEF.md
# Card command and response sequencer

This block starts one command on an attached memory card and collects the card's answer. A host-side register write of the command/data configuration (response type, data-enable, stop-transmission) marks a command as pending. The command goes out as soon as both a pending command and a running card clock exist, whichever of the two arrives last. At that moment the command index and 32-bit argument are presented to the card model as a single-cycle request.

The card model answers with a byte count and up to sixteen bytes. The sequencer compares the byte count with the minimum length for the selected response type. A long enough answer is packed into a nine-entry halfword response store, the end-of-command/response status bit is set and the read pointer is rewound. A short answer sets the response-timeout status bit. An end-of-command interrupt request is raised for every command sent, whatever its outcome. When data-enable is set and the response is good, control passes to the data FIFO through a start pulse and a busy level. The busy level holds until the data side reports completion, or until a new configuration write or a clock stop cancels the transfer.

Top module: `cmd_rsp_seq`

## Requirements
- R1: A configuration write with stop-transmission (`cfg_stop_i`) low while the clock is enabled (status bit 8 set, or `clk_start_i` high in the same cycle) drives `card_req_o` high for exactly one cycle, starting the cycle after the write. During that cycle `card_cmd_o`/`card_arg_o` carry the index and argument present at the write. With `cfg_stop_i` high, no request is issued, either then or on a later clock start.
- R2: A configuration write made while the clock is off issues no request. A later `clk_start_i` issues it, one cycle after the start, provided the stored stop bit is clear.
- R3: At launch, status bits 1 and 13 are cleared and bit 8 is kept. The pending mark is cleared, so a further `clk_start_i` does not send the command again.
- R4: The minimum response length is 0 bytes for type 0, 4 bytes for types 1 and 3, and 16 bytes for type 2. A shorter answer sets status bit 1, leaves bit 13 clear and starts no data phase.
- R5: On a good answer, entry i of the response store holds byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Byte k is `card_rsp_data_i[8k+7:8k]`, and any byte at or beyond the reported count reads as zero. Status bit 13 is set and the read pointer returns to entry 0.
- R6: `end_cmd_irq_o` goes high at every launch and stays high until `end_cmd_clr_i`. A launch in the same cycle as the clear wins.
- R7: `resp_rdata_o` shows the entry at the read pointer, and each `resp_rd_i` pulse advances the pointer. After nine reads the output is zero.
- R8: With data-enable set, a good answer gives a one-cycle `data_start_o` pulse and raises `data_active_o` until `data_done_i`. With data-enable clear, the sequencer goes idle and `data_active_o` stays low.
- R9: A configuration write or `clk_stop_i` cancels an active data phase. `clk_stop_i` clears status bit 8 and blocks any launch in the same cycle.
- R10: The response store is zeroed at launch, so entries not yet read from an earlier command read as zero after a later command times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Command/data configuration write strobe |
| cfg_rsp_type_i | input | 2 | Response type: 0 none, 1/3 short, 2 long |
| cfg_data_en_i | input | 1 | Command has a data phase |
| cfg_stop_i | input | 1 | Stop-transmission bit; holds the command back |
| clk_start_i | input | 1 | Card clock start strobe |
| clk_stop_i | input | 1 | Card clock stop strobe |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| card_req_o | output | 1 | One-cycle command request to card model |
| card_cmd_o | output | 6 | Latched command index |
| card_arg_o | output | 32 | Latched argument |
| card_rsp_valid_i | input | 1 | Card answer valid |
| card_rsp_len_i | input | 5 | Answer byte count |
| card_rsp_data_i | input | 128 | Answer bytes, byte k at bits 8k+7:8k |
| resp_rd_i | input | 1 | Response store read strobe |
| resp_rdata_o | output | 16 | Entry at read pointer, zero past nine |
| status_o | output | 16 | Bit 1 timeout, bit 8 clock on, bit 13 command/response done |
| end_cmd_irq_o | output | 1 | End-of-command interrupt request |
| end_cmd_clr_i | input | 1 | Clears the interrupt request |
| data_start_o | output | 1 | One-cycle hand-over pulse to data FIFO |
| data_active_o | output | 1 | Data phase in progress |
| data_done_i | input | 1 | Data FIFO finished |

## Verification
Commands are sent both ways round (configuration before the clock, and clock already running), so launch gating is tested in each order and the stop bit is shown to hold a command back. Answers are exercised at each response type with lengths just below and at the minimum, plus an odd count and a zero count. These separate a good answer from a timeout and expose any stale byte past the count. Data-enable runs show the hand-over, its completion and its cancellation by a configuration write and by a clock stop. A partially read good answer followed by a timed-out command shows that the store is wiped at launch.

// File: rtl/cmd_rsp_seq_pkg.sv
package cmd_rsp_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_e;

  localparam int unsigned ST_TOUT   = 1;
  localparam int unsigned ST_CLK_ON = 8;
  localparam int unsigned ST_CMD_OK = 13;

  function automatic int unsigned min_rsp_bytes(input logic [1:0] rtype);
    case (rtype)
      2'd0:    return 0;
      2'd2:    return 16;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/seq_launch_ctrl.sv
module seq_launch_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_wr_i,
  input  logic [1:0] cfg_rsp_type_i,
  input  logic       cfg_data_en_i,
  input  logic       cfg_stop_i,
  input  logic       clk_start_i,
  input  logic       clk_stop_i,
  output logic       clk_on_o,
  output logic       launch_o,
  output logic       cancel_o,
  output logic [1:0] eff_rsp_type_o,
  output logic       eff_data_en_o
);
  logic       pend_q, stop_q, clk_on_q, data_en_q;
  logic [1:0] rtype_q;

  // configuration in effect this cycle: a write overrides the stored copy
  assign eff_rsp_type_o = cfg_wr_i ? cfg_rsp_type_i : rtype_q;
  assign eff_data_en_o  = cfg_wr_i ? cfg_data_en_i  : data_en_q;

  always_comb begin
    launch_o = 1'b0;
    if (!clk_stop_i) begin
      if (cfg_wr_i)
        launch_o = !cfg_stop_i && (clk_on_q || clk_start_i);
      else
        launch_o = clk_start_i && pend_q && !stop_q;
    end
  end

  assign cancel_o = cfg_wr_i || clk_stop_i;
  assign clk_on_o = clk_on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      stop_q    <= 1'b0;
      clk_on_q  <= 1'b0;
      data_en_q <= 1'b0;
      rtype_q   <= '0;
    end else begin
      if (cfg_wr_i) begin
        stop_q    <= cfg_stop_i;
        rtype_q   <= cfg_rsp_type_i;
        data_en_q <= cfg_data_en_i;
      end
      if (launch_o)      pend_q <= 1'b0;
      else if (cfg_wr_i) pend_q <= 1'b1;
      if (clk_stop_i)       clk_on_q <= 1'b0;
      else if (clk_start_i) clk_on_q <= 1'b1;
    end
  end
endmodule

// File: rtl/seq_resp_store.sv
module seq_resp_store #(
  parameter int unsigned DEPTH     = 9,
  parameter int unsigned RSP_BYTES = 16,
  localparam int unsigned LEN_W    = $clog2(RSP_BYTES + 1),
  localparam int unsigned IDX_W    = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   load_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [RSP_BYTES*8-1:0] data_i,
  input  logic                   rd_i,
  output logic [15:0]            rdata_o
);
  logic [DEPTH*16-1:0] flat;
  logic [IDX_W-1:0]    idx_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam int unsigned LO = 2 * i;
    localparam int unsigned HI = 2 * i + 1;
    logic [7:0]  lo_b, hi_b;
    logic [15:0] ent_q;

    if (LO < RSP_BYTES) begin : g_lo
      assign lo_b = (int'(len_i) > LO) ? data_i[8*LO +: 8] : 8'h00;
    end else begin : g_lo_z
      assign lo_b = 8'h00;
    end
    if (HI < RSP_BYTES) begin : g_hi
      assign hi_b = (int'(len_i) > HI) ? data_i[8*HI +: 8] : 8'h00;
    end else begin : g_hi_z
      assign hi_b = 8'h00;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ent_q <= '0;
      else if (clear_i) ent_q <= '0;
      else if (load_i)  ent_q <= {hi_b, lo_b};
    end
    assign flat[16*i +: 16] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           idx_q <= '0;
    else if (load_i)                       idx_q <= '0;
    else if (rd_i && (int'(idx_q) < DEPTH)) idx_q <= idx_q + 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < DEPTH; k++)
      if (int'(idx_q) == k) rdata_o = flat[16*k +: 16];
  end
endmodule

// File: rtl/seq_cmd_fsm.sv
module seq_cmd_fsm
  import cmd_rsp_seq_pkg::*;
#(
  parameter int unsigned CMD_W     = 6,
  parameter int unsigned ARG_W     = 32,
  parameter int unsigned RSP_BYTES = 16,
  localparam int unsigned LEN_W    = $clog2(RSP_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             cancel_i,
  input  logic [1:0]       rsp_type_i,
  input  logic             data_en_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [ARG_W-1:0] arg_i,
  input  logic             rsp_valid_i,
  input  logic [LEN_W-1:0] rsp_len_i,
  input  logic             irq_clr_i,
  input  logic             data_done_i,
  output logic             req_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [ARG_W-1:0] arg_o,
  output logic             load_o,
  output logic             tout_o,
  output logic             cmd_ok_o,
  output logic             irq_o,
  output logic             data_start_o,
  output logic             data_active_o
);
  seq_state_e st_q;
  logic [1:0] rtype_q;
  logic       den_q;
  logic       rsp_ok;
  logic       rsp_take;

  assign rsp_ok   = int'(rsp_len_i) >= min_rsp_bytes(rtype_q);
  assign rsp_take = (st_q == SEQ_WAIT) && rsp_valid_i && !launch_i && !cancel_i;
  assign load_o   = rsp_take && rsp_ok;
  assign data_active_o = (st_q == SEQ_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= SEQ_IDLE;
      rtype_q      <= '0;
      den_q        <= 1'b0;
      req_o        <= 1'b0;
      cmd_o        <= '0;
      arg_o        <= '0;
      tout_o       <= 1'b0;
      cmd_ok_o     <= 1'b0;
      irq_o        <= 1'b0;
      data_start_o <= 1'b0;
    end else begin
      req_o        <= 1'b0;
      data_start_o <= 1'b0;
      if (irq_clr_i) irq_o <= 1'b0;
      if (launch_i) begin
        st_q     <= SEQ_WAIT;
        rtype_q  <= rsp_type_i;
        den_q    <= data_en_i;
        cmd_o    <= cmd_i;
        arg_o    <= arg_i;
        req_o    <= 1'b1;
        tout_o   <= 1'b0;
        cmd_ok_o <= 1'b0;
        irq_o    <= 1'b1;
      end else if (cancel_i) begin
        st_q <= SEQ_IDLE;
      end else begin
        case (st_q)
          SEQ_WAIT: if (rsp_take) begin
            if (rsp_ok) begin
              cmd_ok_o <= 1'b1;
              if (den_q) begin
                st_q         <= SEQ_DATA;
                data_start_o <= 1'b1;
              end else begin
                st_q <= SEQ_IDLE;
              end
            end else begin
              tout_o <= 1'b1;
              st_q   <= SEQ_IDLE;
            end
          end
          SEQ_DATA: if (data_done_i) st_q <= SEQ_IDLE;
          default: st_q <= SEQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_rsp_seq.sv
module cmd_rsp_seq
  import cmd_rsp_seq_pkg::*;
#(
  parameter int unsigned CMD_W     = 6,
  parameter int unsigned ARG_W     = 32,
  parameter int unsigned RSP_BYTES = 16,
  parameter int unsigned DEPTH     = 9,
  localparam int unsigned LEN_W    = $clog2(RSP_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_wr_i,
  input  logic [1:0]             cfg_rsp_type_i,
  input  logic                   cfg_data_en_i,
  input  logic                   cfg_stop_i,
  input  logic                   clk_start_i,
  input  logic                   clk_stop_i,
  input  logic [CMD_W-1:0]       cmd_idx_i,
  input  logic [ARG_W-1:0]       cmd_arg_i,
  output logic                   card_req_o,
  output logic [CMD_W-1:0]       card_cmd_o,
  output logic [ARG_W-1:0]       card_arg_o,
  input  logic                   card_rsp_valid_i,
  input  logic [LEN_W-1:0]       card_rsp_len_i,
  input  logic [RSP_BYTES*8-1:0] card_rsp_data_i,
  input  logic                   resp_rd_i,
  output logic [15:0]            resp_rdata_o,
  output logic [15:0]            status_o,
  output logic                   end_cmd_irq_o,
  input  logic                   end_cmd_clr_i,
  output logic                   data_start_o,
  output logic                   data_active_o,
  input  logic                   data_done_i
);
  logic       clk_on, launch, cancel, eff_den, load, tout, cmd_ok;
  logic [1:0] eff_rtype;

  seq_launch_ctrl u_launch (
    .clk_i, .rst_ni,
    .cfg_wr_i, .cfg_rsp_type_i, .cfg_data_en_i, .cfg_stop_i,
    .clk_start_i, .clk_stop_i,
    .clk_on_o       (clk_on),
    .launch_o       (launch),
    .cancel_o       (cancel),
    .eff_rsp_type_o (eff_rtype),
    .eff_data_en_o  (eff_den)
  );

  seq_cmd_fsm #(.CMD_W(CMD_W), .ARG_W(ARG_W), .RSP_BYTES(RSP_BYTES)) u_fsm (
    .clk_i, .rst_ni,
    .launch_i      (launch),
    .cancel_i      (cancel),
    .rsp_type_i    (eff_rtype),
    .data_en_i     (eff_den),
    .cmd_i         (cmd_idx_i),
    .arg_i         (cmd_arg_i),
    .rsp_valid_i   (card_rsp_valid_i),
    .rsp_len_i     (card_rsp_len_i),
    .irq_clr_i     (end_cmd_clr_i),
    .data_done_i   (data_done_i),
    .req_o         (card_req_o),
    .cmd_o         (card_cmd_o),
    .arg_o         (card_arg_o),
    .load_o        (load),
    .tout_o        (tout),
    .cmd_ok_o      (cmd_ok),
    .irq_o         (end_cmd_irq_o),
    .data_start_o  (data_start_o),
    .data_active_o (data_active_o)
  );

  seq_resp_store #(.DEPTH(DEPTH), .RSP_BYTES(RSP_BYTES)) u_store (
    .clk_i, .rst_ni,
    .clear_i (launch),
    .load_i  (load),
    .len_i   (card_rsp_len_i),
    .data_i  (card_rsp_data_i),
    .rd_i    (resp_rd_i),
    .rdata_o (resp_rdata_o)
  );

  always_comb begin
    status_o            = '0;
    status_o[ST_TOUT]   = tout;
    status_o[ST_CLK_ON] = clk_on;
    status_o[ST_CMD_OK] = cmd_ok;
  end
endmodule

// File: rtl/cmd_rsp_seq_chk.sv
module cmd_rsp_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg_wr_i,
  input logic        cfg_stop_i,
  input logic        clk_start_i,
  input logic        clk_stop_i,
  input logic        card_req_o,
  input logic [15:0] status_o,
  input logic        end_cmd_irq_o,
  input logic        data_start_o,
  input logic        data_active_o
);
  // R1
  launch_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && !cfg_stop_i && status_o[8] && !clk_stop_i) |=> card_req_o);
  // R1
  req_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_req_o |=> !card_req_o);
  // R3
  status_cleared_at_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_req_o |-> (!status_o[1] && !status_o[13]));
  // R4
  tout_excl_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({status_o[1], status_o[13]}));
  // R6
  irq_on_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_req_o |-> end_cmd_irq_o);
  // R8
  start_after_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_start_o |-> (status_o[13] && data_active_o));
  // R9
  stop_cancels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_stop_i |=> (!data_active_o && !status_o[8] && !card_req_o));
endmodule

bind cmd_rsp_seq cmd_rsp_seq_chk u_chk (
  .clk_i, .rst_ni, .cfg_wr_i, .cfg_stop_i, .clk_start_i, .clk_stop_i,
  .card_req_o, .status_o, .end_cmd_irq_o, .data_start_o, .data_active_o
);

// File: tb/cmd_rsp_seq_bench.sv
module cmd_rsp_seq_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cfg_wr_i = 0, cfg_data_en_i = 0, cfg_stop_i = 0;
  logic [1:0]   cfg_rsp_type_i = 0;
  logic         clk_start_i = 0, clk_stop_i = 0;
  logic [5:0]   cmd_idx_i = 0;
  logic [31:0]  cmd_arg_i = 0;
  logic         card_req_o;
  logic [5:0]   card_cmd_o;
  logic [31:0]  card_arg_o;
  logic         card_rsp_valid_i = 0;
  logic [4:0]   card_rsp_len_i = 0;
  logic [127:0] card_rsp_data_i = 0;
  logic         resp_rd_i = 0;
  logic [15:0]  resp_rdata_o, status_o;
  logic         end_cmd_irq_o, end_cmd_clr_i = 0;
  logic         data_start_o, data_active_o, data_done_i = 0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  always #10 clk_i = ~clk_i;

  cmd_rsp_seq u_cmd_rsp_seq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  // driver side: expected store contents for an answer
  task automatic push_resp(input int len, input logic [127:0] d);
    for (int i = 0; i < 9; i++) begin
      logic [7:0] lo, hi;
      lo = (2*i < len && 2*i < 16) ? d[16*i +: 8] : 8'h00;
      hi = (2*i+1 < len && 2*i+1 < 16) ? d[16*i+8 +: 8] : 8'h00;
      exp_q.push_back({hi, lo});
    end
  endtask

  // monitor side: pop and compare while reading
  task automatic drain(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [15:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'h0000;
      chk(req, resp_rdata_o, e);
      resp_rd_i = 1; step(); resp_rd_i = 0;
    end
  endtask

  task automatic cfg_write(input logic [1:0] t, input logic den, input logic stp,
                           input logic [5:0] c, input logic [31:0] a);
    cfg_rsp_type_i = t; cfg_data_en_i = den; cfg_stop_i = stp;
    cmd_idx_i = c; cmd_arg_i = a; cfg_wr_i = 1;
    step();
    cfg_wr_i = 0;
  endtask

  task automatic answer(input int len, input logic [127:0] d);
    card_rsp_len_i = 5'(len); card_rsp_data_i = d; card_rsp_valid_i = 1;
    step();
    card_rsp_valid_i = 0;
  endtask

  logic [127:0] pat;

  initial begin
    for (int k = 0; k < 16; k++) pat[8*k +: 8] = 8'hA0 + 8'(k);
    step(); step();
    rst_ni = 1;
    step();
    chk("R3 reset status", status_o, 16'h0000);
    chk("R6 reset irq", end_cmd_irq_o, 0);
    chk("R8 reset active", data_active_o, 0);

    // R2: write with clock off, then start
    cfg_write(2'd1, 0, 0, 6'd17, 32'hDEAD_BEEF);
    chk("R2 no req clock off", card_req_o, 0);
    clk_start_i = 1; step(); clk_start_i = 0;
    chk("R2 req after start", card_req_o, 1);
    chk("R1 cmd", card_cmd_o, 6'd17);
    chk("R1 arg", card_arg_o, 32'hDEAD_BEEF);
    chk("R3 status at launch", status_o, 16'h0100);
    chk("R6 irq at launch", end_cmd_irq_o, 1);
    answer(6, pat);
    chk("R1 req one cycle", card_req_o, 0);
    chk("R5 status ok", status_o, 16'h2100);
    chk("R8 no data start", data_start_o, 0);
    push_resp(6, pat);
    drain(9, "R5 R7 packing");
    drain(2, "R7 zero after nine");
    // R3: pending cleared
    clk_start_i = 1; step(); clk_start_i = 0;
    chk("R3 no relaunch", card_req_o, 0);
    end_cmd_clr_i = 1; step(); end_cmd_clr_i = 0;
    chk("R6 irq cleared", end_cmd_irq_o, 0);

    // R1: stop bit holds command back
    cfg_write(2'd1, 0, 1, 6'd3, 32'h1);
    chk("R1 stop no req", card_req_o, 0);
    clk_start_i = 1; step(); clk_start_i = 0;
    chk("R1 stop no req on start", card_req_o, 0);

    // R5: odd count type 3
    cfg_write(2'd3, 0, 0, 6'd41, 32'h0000_1234);
    chk("R1 req clock on", card_req_o, 1);
    answer(5, pat);
    chk("R5 status ok type3", status_o, 16'h2100);
    push_resp(5, pat);
    drain(2, "R5 partial read");
    exp_q.delete();

    // R4 + R10: type 2 short answer
    cfg_write(2'd2, 1, 0, 6'd2, 32'h0);
    chk("R6 irq each launch", end_cmd_irq_o, 1);
    answer(15, pat);
    chk("R4 timeout status", status_o, 16'h0102);
    chk("R4 no data start", data_start_o, 0);
    chk("R4 not active", data_active_o, 0);
    drain(1, "R10 store wiped");

    // R8: type 2 full answer with data
    cfg_write(2'd2, 1, 0, 6'd18, 32'h55);
    answer(16, pat);
    chk("R8 start pulse", data_start_o, 1);
    chk("R8 active", data_active_o, 1);
    push_resp(16, pat);
    drain(9, "R5 long answer");
    chk("R8 held active", data_active_o, 1);
    data_done_i = 1; step(); data_done_i = 0;
    chk("R8 done idle", data_active_o, 0);

    // R4: type 0, zero bytes ok
    cfg_write(2'd0, 0, 0, 6'd0, 32'h0);
    answer(0, pat);
    chk("R4 type0 ok", status_o, 16'h2100);

    // R4: type 1 short
    cfg_write(2'd1, 0, 0, 6'd13, 32'h0);
    answer(3, pat);
    chk("R4 type1 short", status_o, 16'h0102);

    // R9: cancel by config write
    cfg_write(2'd1, 1, 0, 6'd24, 32'h9);
    answer(4, pat);
    chk("R8 active before cancel", data_active_o, 1);
    cfg_write(2'd1, 1, 1, 6'd24, 32'h9);
    chk("R9 write cancels", data_active_o, 0);
    chk("R9 no req stop", card_req_o, 0);

    // R9: cancel by clock stop, launch blocked
    cfg_write(2'd1, 1, 0, 6'd25, 32'h7);
    answer(4, pat);
    chk("R8 active again", data_active_o, 1);
    clk_stop_i = 1; step(); clk_stop_i = 0;
    chk("R9 stop cancels", data_active_o, 0);
    chk("R9 clock bit off", status_o[8], 0);
    clk_start_i = 1; step(); clk_start_i = 0;
    cfg_write(2'd1, 0, 0, 6'd26, 32'h0);
    step();
    clk_stop_i = 1; cfg_rsp_type_i = 1; cfg_stop_i = 0; cfg_wr_i = 1;
    step();
    clk_stop_i = 0; cfg_wr_i = 0;
    chk("R9 stop blocks launch", card_req_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule